// File: doc/BRIEF.md
# Core Power State Controller

This block governs the energy state of a single processor core. While the core runs it produces a per-cycle core clock enable that divides the core rate by 1, 2 or 3. An idle request blocks that enable and leaves the peripheral clock running. An interrupt lifts the block and the core resumes at the divider it had before. Software commands move the core into one of three low-power states:
- light sleep, where the PLL keeps running;
- deep sleep, where the PLL is switched off;
- power-off.

Wake-up from light sleep is immediate. Wake-up from deep sleep turns the PLL back on and holds every clock until the PLL reports lock or a programmable cycle limit runs out. Power-off is left only through reset.

Software drives the block through a small write port with three addresses. Address 0 selects the divider, address 1 issues a state command and address 2 sets the relock limit. The PLL and the clock gating cells sit outside the block and consume its enables.

Top module: `core_pwr_ctrl`

## Requirements
- R1: After reset the state code is 0 (active), div_sel is 0, core_clk_en and io_clk_en are high on every cycle, pll_en is high and pwr_off_req is low.
- R2: A write to address 0 with code 0, 1 or 2 in wr_data[1:0] selects divide-by-1, 2 or 3. In active and not idle, core_clk_en is then high in exactly 6, 3 or 2 cycles of any 6-cycle window. Code 3 is ignored and leaves the divider unchanged.
- R3: A new divider is applied only at the boundary of a 6-cycle phase counter. The counter runs from 0 at reset release while active, so the new div_sel first appears after rising edge k (counted from reset release) where (k-1) mod 6 = 0. div_ack is high for exactly that one cycle.
- R4: A one-cycle idle_req in active drives core_clk_en low and keeps io_clk_en high. A later irq restores core_clk_en with the divider selected before the idle.
- R5: Command code 1 written to address 1 enters sleep (state code 1): core_clk_en and io_clk_en are low and pll_en stays high. rtc_wake or ext_wake returns the state to active on the next cycle.
- R6: Command code 2 enters deep sleep (state code 2) with pll_en low. A wake moves to relock (state code 3) with pll_en high and both clock enables low. pll_lock high then returns to active on the next cycle.
- R7: The relock limit L is written to address 2 and defaults to LOCK_DEF. Without lock, relock lasts exactly L+1 cycles and then the block returns to active.
- R8: Command code 3 enters power-off (state code 4): pwr_off_req is high and pll_en and both clock enables are low. Wakes and writes have no effect in this state. Only reset leaves it, returning to R1 conditions.
- R9: State commands are accepted only in active, and wake inputs have no effect in active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset, the only exit from power-off |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 divider, 1 state command, 2 relock limit |
| wr_data | input | LOCK_W | Write data |
| idle_req | input | 1 | Idle instruction pending |
| irq | input | 1 | Interrupt, ends idle gating |
| rtc_wake | input | 1 | Real-time clock timeout wake |
| ext_wake | input | 1 | External trigger wake |
| pll_lock | input | 1 | PLL lock indication |
| core_clk_en | output | 1 | Core clock enable, divided |
| io_clk_en | output | 1 | Peripheral clock enable |
| div_sel | output | 2 | Applied divider code |
| div_ack | output | 1 | One-cycle pulse when a divider change takes effect |
| pll_en | output | 1 | PLL enable |
| pwr_off_req | output | 1 | Power-off request |
| state_o | output | 3 | State code: 0 active, 1 sleep, 2 deep, 3 relock, 4 off |

## Verification
The bench looks for four kinds of error.
- A divider applied mid-phase would place the acknowledge off the 6-cycle boundary.
- An idle release that loses the divider would show a full-rate window after the interrupt.
- A relock counter off by one would hold relock one cycle too long or too short.
- A leaky power-off state would answer a wake or a command.

It also tries the ignored cases, which are code 3, commands outside active and wakes in active, and checks that none of them changes the ports.

// File: rtl/core_pwr_pkg.sv
package core_pwr_pkg;
  typedef enum logic [2:0] {
    PS_ACTIVE = 3'd0,
    PS_SLEEP  = 3'd1,
    PS_DEEP   = 3'd2,
    PS_RELOCK = 3'd3,
    PS_OFF    = 3'd4
  } pstate_t;

  localparam logic [1:0] CMD_SLEEP = 2'd1;
  localparam logic [1:0] CMD_DEEP  = 2'd2;
  localparam logic [1:0] CMD_OFF   = 2'd3;
  localparam int unsigned PHASE_LEN = 6;  // common multiple of 1,2,3

  // core enable tick for a given phase and divider code
  function automatic logic div_tick(input logic [2:0] ph, input logic [1:0] sel);
    case (sel)
      2'd1:    return (ph[0] == 1'b0);
      2'd2:    return (ph == 3'd0) || (ph == 3'd3);
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic div_code_ok(input logic [1:0] sel);
    return sel != 2'd3;
  endfunction
endpackage

// File: rtl/core_pwr_clkdiv.sv
module core_pwr_clkdiv
  import core_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       wr_div,
  input  logic [1:0] wr_code,
  output logic [1:0] div_sel,
  output logic       div_ack,
  output logic       tick
);
  localparam int unsigned PH_W = $clog2(PHASE_LEN);

  logic [PH_W-1:0] phase;
  logic [1:0]      div_nxt;
  logic            pend;
  logic            apply_now;

  assign apply_now = run && pend && (phase == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= '0;
      div_sel <= 2'd0;
      div_nxt <= 2'd0;
      pend    <= 1'b0;
      div_ack <= 1'b0;
    end else begin
      div_ack <= 1'b0;
      if (run) phase <= (phase == PH_W'(PHASE_LEN - 1)) ? '0 : phase + 1'b1;
      else     phase <= '0;
      if (apply_now) begin
        div_sel <= div_nxt;
        pend    <= 1'b0;
        div_ack <= 1'b1;
      end
      if (wr_div && div_code_ok(wr_code)) begin
        div_nxt <= wr_code;
        pend    <= 1'b1;
      end
    end
  end

  assign tick = div_tick(3'(phase), div_sel);

  assert_sel_change_acked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel != $past(div_sel)) |-> div_ack);
  assert_ack_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_ack |=> !div_ack);
  assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_sel != 2'd3);
endmodule

// File: rtl/core_pwr_fsm.sv
module core_pwr_fsm
  import core_pwr_pkg::*;
#(
  parameter int unsigned LOCK_W   = 16,
  parameter int unsigned LOCK_DEF = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic [1:0]        cmd_code,
  input  logic              wr_lim,
  input  logic [LOCK_W-1:0] lim_val,
  input  logic              idle_req,
  input  logic              irq,
  input  logic              rtc_wake,
  input  logic              ext_wake,
  input  logic              pll_lock,
  output pstate_t           state,
  output logic              gated,
  output logic              pll_en,
  output logic              pwr_off_req
);
  logic [LOCK_W-1:0] cnt;
  logic [LOCK_W-1:0] lim;
  logic              wake;
  logic              relock_done;

  assign wake        = rtc_wake || ext_wake;
  assign relock_done = pll_lock || (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PS_ACTIVE;
      gated <= 1'b0;
      cnt   <= '0;
      lim   <= LOCK_W'(LOCK_DEF);
    end else begin
      if (wr_lim && state != PS_OFF) lim <= lim_val;
      case (state)
        PS_ACTIVE: begin
          if (irq)           gated <= 1'b0;
          else if (idle_req) gated <= 1'b1;
          if (wr_cmd) begin
            case (cmd_code)
              CMD_SLEEP: begin state <= PS_SLEEP; gated <= 1'b0; end
              CMD_DEEP:  begin state <= PS_DEEP;  gated <= 1'b0; end
              CMD_OFF:   begin state <= PS_OFF;   gated <= 1'b0; end
              default: ;
            endcase
          end
        end
        PS_SLEEP:  if (wake) state <= PS_ACTIVE;
        PS_DEEP:   if (wake) begin state <= PS_RELOCK; cnt <= '0; end
        PS_RELOCK: begin
          if (relock_done) state <= PS_ACTIVE;
          else             cnt   <= cnt + 1'b1;
        end
        default: state <= PS_OFF;
      endcase
    end
  end

  assign pll_en      = !(state == PS_DEEP || state == PS_OFF);
  assign pwr_off_req = (state == PS_OFF);

  assert_off_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_OFF) |=> (state == PS_OFF));
  assert_relock_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_RELOCK) |-> (cnt <= lim));
  assert_lock_exits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_RELOCK && pll_lock) |=> (state == PS_ACTIVE));
  assert_sleep_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_SLEEP && wake) |=> (state == PS_ACTIVE));
  assert_active_ignores_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_ACTIVE && !wr_cmd) |=> (state == PS_ACTIVE));
endmodule

// File: rtl/core_pwr_ctrl.sv
module core_pwr_ctrl
  import core_pwr_pkg::*;
#(
  parameter int unsigned LOCK_W   = 16,
  parameter int unsigned LOCK_DEF = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [LOCK_W-1:0] wr_data,
  input  logic              idle_req,
  input  logic              irq,
  input  logic              rtc_wake,
  input  logic              ext_wake,
  input  logic              pll_lock,
  output logic              core_clk_en,
  output logic              io_clk_en,
  output logic [1:0]        div_sel,
  output logic              div_ack,
  output logic              pll_en,
  output logic              pwr_off_req,
  output logic [2:0]        state_o
);
  pstate_t state;
  logic    gated;
  logic    tick;
  logic    active;
  logic    wr_div, wr_cmd, wr_lim;

  assign wr_div = wr_en && (wr_addr == 2'd0);
  assign wr_cmd = wr_en && (wr_addr == 2'd1);
  assign wr_lim = wr_en && (wr_addr == 2'd2);
  assign active = (state == PS_ACTIVE);

  core_pwr_clkdiv u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (active),
    .wr_div  (wr_div),
    .wr_code (wr_data[1:0]),
    .div_sel (div_sel),
    .div_ack (div_ack),
    .tick    (tick)
  );

  core_pwr_fsm #(.LOCK_W(LOCK_W), .LOCK_DEF(LOCK_DEF)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_cmd      (wr_cmd),
    .cmd_code    (wr_data[1:0]),
    .wr_lim      (wr_lim),
    .lim_val     (wr_data),
    .idle_req    (idle_req),
    .irq         (irq),
    .rtc_wake    (rtc_wake),
    .ext_wake    (ext_wake),
    .pll_lock    (pll_lock),
    .state       (state),
    .gated       (gated),
    .pll_en      (pll_en),
    .pwr_off_req (pwr_off_req)
  );

  assign core_clk_en = active && !gated && tick;
  assign io_clk_en   = active;
  assign state_o     = state;

  assert_idle_keeps_io_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && active) |-> (io_clk_en && !core_clk_en));
  assert_low_power_clocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 3'd0) |-> (!core_clk_en && !io_clk_en));
  assert_deep_pll_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2) |-> !pll_en);
endmodule

// File: tb/tb_core_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_core_pwr_ctrl;
  localparam int LW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [LW-1:0] wr_data = '0;
  logic idle_req = 1'b0, irq = 1'b0, rtc_wake = 1'b0, ext_wake = 1'b0, pll_lock = 1'b0;
  logic core_clk_en, io_clk_en, div_ack, pll_en, pwr_off_req;
  logic [1:0] div_sel;
  logic [2:0] state_o;

  int checks = 0, fails = 0, ecount = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ecount = 0;
    else ecount = ecount + 1;
  end

  core_pwr_ctrl #(.LOCK_W(LW), .LOCK_DEF(100)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .idle_req(idle_req), .irq(irq), .rtc_wake(rtc_wake), .ext_wake(ext_wake),
    .pll_lock(pll_lock), .core_clk_en(core_clk_en), .io_clk_en(io_clk_en),
    .div_sel(div_sel), .div_ack(div_ack), .pll_en(pll_en),
    .pwr_off_req(pwr_off_req), .state_o(state_o)
  );

  // {code[4:3], expected highs in 6 cycles [2:0]}
  localparam logic [4:0] VEC [6] = '{
    {2'd0, 3'd6}, {2'd2, 3'd2}, {2'd1, 3'd3}, {2'd3, 3'd3}, {2'd2, 3'd2}, {2'd0, 3'd6}
  };
  localparam logic [1:0] VSEL [6] = '{2'd0, 2'd2, 2'd1, 2'd1, 2'd2, 2'd0};

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [LW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic count6(output int c);
    c = 0;
    for (int i = 0; i < 6; i++) begin
      if (core_clk_en) c++;
      step();
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; step(); s = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int c, k;
    step(2);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 state", state_o, 0);
    check("R1 div_sel", div_sel, 0);
    check("R1 pll_en", pll_en, 1);
    check("R1 pwr_off_req", pwr_off_req, 0);
    check("R1 io_clk_en", io_clk_en, 1);
    count6(c);
    check("R1 core full rate", c, 6);

    // R3 divider applied on phase boundary, one-cycle ack
    wr(2'd0, 16'd1);
    k = 0;
    while (!div_ack && k < 10) begin step(); k++; end
    check("R3 ack seen", div_ack, 1);
    check("R3 ack on boundary", (ecount - 1) % 6, 0);
    check("R3 new sel with ack", div_sel, 1);
    step();
    check("R3 ack single cycle", div_ack, 0);

    // R2 table walk
    for (int v = 0; v < 6; v++) begin
      wr(2'd0, {14'd0, VEC[v][4:3]});
      step(8);
      check("R2 div_sel", div_sel, VSEL[v]);
      count6(c);
      check("R2 enable count", c, VEC[v][2:0]);
    end

    // R4 idle gating with divide by 3
    wr(2'd0, 16'd2);
    step(8);
    pulse(idle_req);
    count6(c);
    check("R4 core gated", c, 0);
    check("R4 io running", io_clk_en, 1);
    pulse(irq);
    count6(c);
    check("R4 divider restored", c, 2);

    // R9 wake in active ignored
    pulse(rtc_wake);
    pulse(ext_wake);
    check("R9 wake ignored", state_o, 0);

    // R5 sleep, rtc wake
    wr(2'd1, 16'd1);
    check("R5 sleep state", state_o, 1);
    check("R5 core off", core_clk_en, 0);
    check("R5 io off", io_clk_en, 0);
    check("R5 pll on", pll_en, 1);
    wr(2'd1, 16'd2);
    check("R9 cmd ignored in sleep", state_o, 1);
    pulse(rtc_wake);
    check("R5 rtc wake", state_o, 0);
    check("R5 io back", io_clk_en, 1);
    wr(2'd1, 16'd1);
    pulse(ext_wake);
    check("R5 ext wake", state_o, 0);

    // R6 deep sleep and lock
    wr(2'd1, 16'd2);
    check("R6 deep state", state_o, 2);
    check("R6 pll off", pll_en, 0);
    pulse(ext_wake);
    check("R6 relock state", state_o, 3);
    check("R6 pll on", pll_en, 1);
    step(3);
    check("R6 still relock", state_o, 3);
    check("R6 core off", core_clk_en, 0);
    pulse(pll_lock);
    check("R6 locked active", state_o, 0);

    // R7 timeout with limit 5
    wr(2'd2, 16'd5);
    wr(2'd1, 16'd2);
    pulse(rtc_wake);
    check("R7 relock entered", state_o, 3);
    step(5);
    check("R7 relock at L", state_o, 3);
    step();
    check("R7 active after L+1", state_o, 0);
    count6(c);
    check("R7 divider kept", c, 2);

    // R8 power off
    wr(2'd1, 16'd3);
    check("R8 off state", state_o, 4);
    check("R8 req", pwr_off_req, 1);
    check("R8 pll off", pll_en, 0);
    check("R8 core off", core_clk_en, 0);
    pulse(rtc_wake);
    pulse(ext_wake);
    pulse(pll_lock);
    wr(2'd1, 16'd1);
    wr(2'd0, 16'd0);
    check("R8 sticky", state_o, 4);
    check("R8 io off", io_clk_en, 0);
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    check("R8 reset exits", state_o, 0);
    check("R8 full rate sel", div_sel, 0);
    count6(c);
    check("R8 full rate", c, 6);

    finish_up();
  end
endmodule